// File: doc/BRIEF.md
# Physical Address Space Decoder

This block sits between a processor's physical bus and its memory-side targets. Every request presents a 22-bit byte address, a write flag and a size flag (word or byte). In the same cycle the block decides where the request goes:

- The local word RAM, which is built into the block.
- A peripheral window at the top of the address space. It is forwarded on a narrower 18-bit peripheral port.
- The processor status word, a register held inside the block at a fixed place in that window.
- One of three error responses.

All decoding is combinational. The only state the block holds is the RAM contents and the status word. Writes to them take effect at the clock edge that closes the request cycle.

Word accesses must be aligned. A misaligned word access is refused before any target is touched.

Above the RAM, the address range up to the start of the peripheral window has nothing behind it, and any access there is refused as nonexistent.

Inside the window, a peripheral claims its own addresses by raising an acknowledge in the same cycle. A forwarded access that nobody claims ends in a bus timeout.

Top module: `paddr_router`

## Requirements
- R1: A word access (acc_byte=0) whose address has bit 0 set raises err_odd. This check wins over every other decode. The access then reaches no target: io_req stays low, and neither RAM nor status word changes.
- R2: An address at or above 0x3C0000 selects the peripheral window. Such an access, unless it is the status word or misaligned, raises io_req and drives io_addr with the address ANDed with 0x3FFFF.
- R3: An address below RAM_BYTES reaches the RAM, with addr>>1 as the word index. A word read returns the last word written to that index.
- R4: An address that is neither below RAM_BYTES nor in the peripheral window raises err_nxm, unless R1 applies.
- R5: A RAM byte write changes only one lane of the word, and the other lane keeps its value. Address bit 0 = 1 selects bits 15:8, and 0 selects bits 7:0. The data is taken from wdata[7:0]. A RAM byte read returns the selected lane in rdata[7:0] with rdata[15:8]=0.
- R6: A peripheral-window byte access drives io_byte=1 and forwards the byte on io_wdata[7:0]. The read result is io_rdata[7:0], zero-extended. A word access drives io_byte=0 and passes all 16 bits both ways.
- R7: The status word lives at peripheral address 0x3FFFE (full address 0x3FFFFE) and resets to 0. It is read and written as a word there. A byte access at 0x3FFFFE reaches its low byte, and one at 0x3FFFFF reaches its high byte. Status-word accesses never raise io_req.
- R8: A forwarded access with io_ack low raises err_tmo, and io_we stays low.
- R9: At most one error flag is high at a time. Each error flag is high only in the cycle of the request that caused it. While any error is high, rdata=0, done=0 and io_we=0.
- R10: done is high in exactly the request cycles with no error, and rdata carries read data only in those cycles. With req low, every output except io_addr, io_byte and io_wdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (status word) |
| req | input | 1 | Request strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| addr | input | ADDR_W | Physical byte address |
| wdata | input | 16 | Write data (byte writes use bits 7:0) |
| rdata | output | 16 | Read data, valid when done and not we |
| done | output | 1 | Access completed without error |
| err_odd | output | 1 | Misaligned word access |
| err_nxm | output | 1 | Nonexistent memory |
| err_tmo | output | 1 | Peripheral access not claimed |
| io_req | output | 1 | Peripheral window access presented |
| io_we | output | 1 | Peripheral write commit (claimed writes only) |
| io_byte | output | 1 | Peripheral access is a byte access |
| io_addr | output | IO_W | Peripheral address (low 18 bits) |
| io_wdata | output | 16 | Peripheral write data |
| io_rdata | input | 16 | Peripheral read data |
| io_ack | input | 1 | Peripheral claims io_addr this cycle |

## Verification
The bench builds the block with RAM_BYTES=256. At that size, the last RAM word (0xFE) and the first nonexistent address (0x100) are both close to the bottom of the map, so the full RAM can be filled and checked word by word. Its bench-side peripheral claims only eight bytes at 0x3F900. This leaves most of the window unclaimed, which puts the timeout path and the claimed path side by side. The status word sits at its fixed top address. Random phases mix all five target classes with both access sizes, and with odd addresses in each class.

// File: rtl/pad_pkg.sv
package pad_pkg;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_RAM  = 2'd1,
        TGT_IO   = 2'd2,
        TGT_PSW  = 2'd3
    } tgt_e;

    function automatic logic [7:0] pick_lane(input logic [15:0] w, input logic hi);
        return hi ? w[15:8] : w[7:0];
    endfunction

endpackage

// File: rtl/pad_decode.sv
module pad_decode
    import pad_pkg::*;
#(
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned RAM_BYTES = 512,
    parameter int unsigned IO_W      = 18,
    parameter int unsigned IO_BASE   = 32'h3C0000,
    parameter int unsigned PSW_OFF   = 32'h3FFFE
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              acc_byte,
    output tgt_e              tgt,
    output logic              odd_err,
    output logic              nxm_err
);
    localparam logic [ADDR_W-1:0] RAM_END  = ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] IO_START = ADDR_W'(IO_BASE);
    localparam logic [IO_W-1:0]   PSW_LOC  = IO_W'(PSW_OFF);

    logic in_io, in_ram, psw_hit;

    always_comb begin
        in_io   = (addr >= IO_START);
        in_ram  = (addr < RAM_END);
        psw_hit = in_io && (addr[IO_W-1:1] == PSW_LOC[IO_W-1:1]);
        odd_err = !acc_byte && addr[0];
        nxm_err = 1'b0;
        tgt     = TGT_NONE;
        if (odd_err) begin
            tgt = TGT_NONE;
        end else if (in_io) begin
            tgt = psw_hit ? TGT_PSW : TGT_IO;
        end else if (in_ram) begin
            tgt = TGT_RAM;
        end else begin
            nxm_err = 1'b1;
        end
    end

endmodule

// File: rtl/pad_ram.sv
module pad_ram #(
    parameter int unsigned WORDS = 256,
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic             wr_byte,
    input  logic             wr_hi,
    input  logic [IDX_W-1:0] idx,
    input  logic [15:0]      wdata,
    output logic [15:0]      rdata
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic [7:0] mem [WORDS];
        logic       lane_we;
        logic [7:0] lane_d;

        assign lane_we = wr_en && (!wr_byte || (wr_hi == 1'(g)));
        assign lane_d  = wr_byte ? wdata[7:0] : wdata[8*g +: 8];

        always_ff @(posedge clk) begin
            if (lane_we) begin
                mem[idx] <= lane_d;
            end
        end

        assign rdata[8*g +: 8] = mem[idx];
    end

endmodule

// File: rtl/pad_psw.sv
module pad_psw (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_byte,
    input  logic        wr_hi,
    input  logic [15:0] wdata,
    output logic [15:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            if (!wr_byte) begin
                q <= wdata;
            end else if (wr_hi) begin
                q[15:8] <= wdata[7:0];
            end else begin
                q[7:0] <= wdata[7:0];
            end
        end
    end

    // R7: a word write lands whole
    p_psw_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_byte) |=> (q == $past(wdata)));

    // R7: a high-byte write leaves the low byte alone
    p_psw_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_byte && wr_hi) |=> $stable(q[7:0]));

endmodule

// File: rtl/paddr_router.sv
module paddr_router
    import pad_pkg::*;
#(
    parameter int unsigned RAM_BYTES = 512,
    parameter int unsigned ADDR_W    = 22,
    parameter int unsigned IO_W      = 18,
    parameter int unsigned IO_BASE   = 32'h3C0000,
    parameter int unsigned PSW_OFF   = 32'h3FFFE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              acc_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              done,
    output logic              err_odd,
    output logic              err_nxm,
    output logic              err_tmo,
    output logic              io_req,
    output logic              io_we,
    output logic              io_byte,
    output logic [IO_W-1:0]   io_addr,
    output logic [15:0]       io_wdata,
    input  logic [15:0]       io_rdata,
    input  logic              io_ack
);
    localparam int unsigned       RAM_WORDS = RAM_BYTES / 2;
    localparam int unsigned       IDX_W     = $clog2(RAM_WORDS);
    localparam logic [ADDR_W-1:0] RAM_END   = ADDR_W'(RAM_BYTES);
    localparam logic [ADDR_W-1:0] IO_START  = ADDR_W'(IO_BASE);

    tgt_e        tgt;
    logic        dec_odd, dec_nxm;
    logic        any_err, ok, rd_ok;
    logic        ram_we, psw_we;
    logic [15:0] ram_rd, psw_q, word_rd;

    pad_decode #(
        .ADDR_W(ADDR_W), .RAM_BYTES(RAM_BYTES), .IO_W(IO_W),
        .IO_BASE(IO_BASE), .PSW_OFF(PSW_OFF)
    ) u_dec (
        .addr(addr), .acc_byte(acc_byte), .tgt(tgt),
        .odd_err(dec_odd), .nxm_err(dec_nxm)
    );

    pad_ram #(.WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .wr_en(ram_we), .wr_byte(acc_byte), .wr_hi(addr[0]),
        .idx(addr[IDX_W:1]), .wdata(wdata), .rdata(ram_rd)
    );

    pad_psw u_psw (
        .clk(clk), .rst_n(rst_n), .wr_en(psw_we), .wr_byte(acc_byte),
        .wr_hi(addr[0]), .wdata(wdata), .q(psw_q)
    );

    always_comb begin
        err_odd = req && dec_odd;
        err_nxm = req && dec_nxm;
        io_req  = req && (tgt == TGT_IO);
        err_tmo = io_req && !io_ack;
        any_err = err_odd || err_nxm || err_tmo;
        ok      = req && !any_err;
        rd_ok   = ok && !we;
        done    = ok;
        ram_we  = ok && we && (tgt == TGT_RAM);
        psw_we  = ok && we && (tgt == TGT_PSW);
        io_we   = io_req && io_ack && we;
        io_byte = acc_byte;
        io_addr = addr[IO_W-1:0];
        io_wdata = wdata;
    end

    always_comb begin
        unique case (tgt)
            TGT_RAM: word_rd = ram_rd;
            TGT_PSW: word_rd = psw_q;
            TGT_IO:  word_rd = io_rdata;
            default: word_rd = '0;
        endcase
        if (!rd_ok) begin
            rdata = '0;
        end else if (!acc_byte) begin
            rdata = word_rd;
        end else if (tgt == TGT_IO) begin
            rdata = {8'h00, io_rdata[7:0]};
        end else begin
            rdata = {8'h00, pick_lane(word_rd, addr[0])};
        end
    end

    // R1: misaligned word access is refused and forwards nothing
    p_odd_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !acc_byte && addr[0]) |-> (err_odd && !io_req && !done));

    // R2: the peripheral port is only used inside the window
    p_io_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> (addr >= IO_START));

    // R4: the hole between RAM and the window is nonexistent
    p_nxm_hole_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (acc_byte || !addr[0]) && addr >= RAM_END && addr < IO_START) |-> err_nxm);

    // R8: an unclaimed forward times out and commits no write
    p_tmo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !io_ack) |-> (err_tmo && !io_we));

    // R9: error flags are exclusive
    p_err_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_odd, err_nxm, err_tmo}));

    // R9: an error silences data and commits
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_odd || err_nxm || err_tmo) |-> (!done && !io_we && rdata == 16'h0));

    // R10: idle cycles are quiet
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> (!done && !io_req && !io_we && !err_odd && !err_nxm && !err_tmo && rdata == 16'h0));

endmodule

// File: tb/paddr_router_tb_top.sv
`timescale 1ns/1ps
module paddr_router_tb_top;

    localparam int unsigned RB = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, acc_byte = 1'b0;
    logic [21:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, io_wdata, io_rdata;
    logic        done, err_odd, err_nxm, err_tmo, io_req, io_we, io_byte, io_ack;
    logic [17:0] io_addr;

    int vectors = 0;
    int miscompares = 0;

    always #2.5 clk = ~clk;

    paddr_router #(.RAM_BYTES(RB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .acc_byte(acc_byte),
        .addr(addr), .wdata(wdata), .rdata(rdata), .done(done),
        .err_odd(err_odd), .err_nxm(err_nxm), .err_tmo(err_tmo),
        .io_req(io_req), .io_we(io_we), .io_byte(io_byte), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ack(io_ack)
    );

    // bench-side peripheral: four words at 0x3F900..0x3F907
    logic [15:0] per_regs [4];
    logic        claim;
    assign claim   = io_req && (io_addr[17:3] == 15'h7F20);
    assign io_ack  = claim;
    assign io_rdata = !claim ? 16'hDEAD :
                      !io_byte ? per_regs[io_addr[2:1]] :
                      (io_addr[0] ? {8'h00, per_regs[io_addr[2:1]][15:8]}
                                  : {8'h00, per_regs[io_addr[2:1]][7:0]});
    always @(posedge clk) begin
        if (io_we) begin
            if (!io_byte) per_regs[io_addr[2:1]] <= io_wdata;
            else if (io_addr[0]) per_regs[io_addr[2:1]][15:8] <= io_wdata[7:0];
            else per_regs[io_addr[2:1]][7:0] <= io_wdata[7:0];
        end
    end

    // reference model state
    logic [15:0] m_ram [RB/2];
    logic [15:0] m_per [4];
    logic [15:0] m_psw;

    task automatic acc(input bit w, input bit b, input logic [21:0] a,
                       input logic [15:0] d, input string tag);
        bit e_odd, e_io, e_ram, e_psw, e_ioreq, e_claim, e_tmo, e_nxm, e_err, e_iowe;
        logic [15:0] e_rd, src;
        bit bad;
        e_odd   = !b && a[0];
        e_io    = a >= 22'h3C0000;
        e_ram   = a < RB;
        e_psw   = e_io && (a[17:1] == 17'h1FFFF);
        e_ioreq = !e_odd && e_io && !e_psw;
        e_claim = e_ioreq && (a[17:3] == 15'h7F20);
        e_tmo   = e_ioreq && !e_claim;
        e_nxm   = !e_odd && !e_io && !e_ram;
        e_err   = e_odd || e_nxm || e_tmo;
        e_iowe  = e_claim && w;
        src = 16'h0;
        if (e_psw) src = m_psw;
        else if (e_claim) src = m_per[a[2:1]];
        else if (e_ram && !e_odd) src = m_ram[a >> 1];
        e_rd = 16'h0;
        if (!e_err && !w) e_rd = !b ? src : (a[0] ? {8'h00, src[15:8]} : {8'h00, src[7:0]});
        @(negedge clk);
        req = 1'b1; we = w; acc_byte = b; addr = a; wdata = d;
        #1;
        vectors++;
        bad = (rdata !== e_rd) || (done !== !e_err) || (err_odd !== e_odd) ||
              (err_nxm !== e_nxm) || (err_tmo !== e_tmo) || (io_req !== e_ioreq) ||
              (io_we !== e_iowe) || (e_ioreq && (io_addr !== a[17:0] || io_byte !== b));
        if (e_iowe && (b ? io_wdata[7:0] !== d[7:0] : io_wdata !== d)) bad = 1;
        if (bad) begin
            miscompares++;
            $display("FAIL %s a=%h w=%0d b=%0d: act rd=%h done=%b odd=%b nxm=%b tmo=%b ioreq=%b iowe=%b ioaddr=%h | exp rd=%h done=%b odd=%b nxm=%b tmo=%b ioreq=%b iowe=%b ioaddr=%h",
                     tag, a, w, b, rdata, done, err_odd, err_nxm, err_tmo, io_req, io_we, io_addr,
                     e_rd, !e_err, e_odd, e_nxm, e_tmo, e_ioreq, e_iowe, a[17:0]);
        end
        if (w && !e_err) begin
            if (e_psw) begin
                if (!b) m_psw = d; else if (a[0]) m_psw[15:8] = d[7:0]; else m_psw[7:0] = d[7:0];
            end else if (e_claim) begin
                if (!b) m_per[a[2:1]] = d;
                else if (a[0]) m_per[a[2:1]][15:8] = d[7:0];
                else m_per[a[2:1]][7:0] = d[7:0];
            end else begin
                if (!b) m_ram[a >> 1] = d;
                else if (a[0]) m_ram[a >> 1][15:8] = d[7:0];
                else m_ram[a >> 1][7:0] = d[7:0];
            end
        end
        @(posedge clk);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        #1;
        vectors++;
        if (done || err_odd || err_nxm || err_tmo || io_req || io_we || rdata !== 16'h0) begin
            miscompares++;
            $display("FAIL %s idle: act done=%b odd=%b nxm=%b tmo=%b ioreq=%b iowe=%b rd=%h exp all 0",
                     tag, done, err_odd, err_nxm, err_tmo, io_req, io_we, rdata);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        m_psw = 16'h0;
        for (int i = 0; i < 4; i++) m_per[i] = 16'h0;
        for (int i = 0; i < int'(RB/2); i++) m_ram[i] = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        idle_check("R10 after reset");
        acc(0, 0, 22'h3FFFFE, 16'h0, "R7 psw reset value");

        // fill RAM so every word has a known value
        for (int i = 0; i < int'(RB/2); i++) acc(1, 0, 22'(2*i), 16'(i * 16'h0101 + 16'h5A00), "R3 fill");
        acc(0, 0, 22'h000000, 16'h0, "R3 first word");
        acc(0, 0, 22'h0000FE, 16'h0, "R3 last word");
        acc(1, 0, 22'h000002, 16'h1357, "R3 word write");
        acc(0, 0, 22'h000002, 16'h0, "R3 word read");

        acc(1, 1, 22'h000003, 16'hFFAB, "R5 high byte write");
        acc(0, 0, 22'h000002, 16'h0, "R5 other lane kept");
        acc(1, 1, 22'h000002, 16'h00CD, "R5 low byte write");
        acc(0, 1, 22'h000002, 16'h0, "R5 low byte read");
        acc(0, 1, 22'h000003, 16'h0, "R5 high byte read");

        acc(1, 0, 22'h000005, 16'hBEEF, "R1 odd word write");
        acc(0, 0, 22'h000004, 16'h0, "R1 word unchanged");
        acc(0, 0, 22'h000101, 16'h0, "R1 odd beats nxm");
        acc(1, 0, 22'h3FF903, 16'h1111, "R1 odd in window");

        acc(0, 0, 22'h000100, 16'h0, "R4 first hole word");
        acc(1, 1, 22'h000100, 16'h0077, "R4 hole byte write");
        acc(0, 0, 22'h3BFFFE, 16'h0, "R4 top of hole");
        idle_check("R9 error is one cycle");

        for (int i = 0; i < 4; i++) acc(1, 0, 22'h3FF900 + 22'(2*i), 16'(16'hA000 + i), "R2 peripheral fill");
        acc(0, 0, 22'h3FF902, 16'h0, "R2 peripheral word read");
        acc(1, 1, 22'h3FF905, 16'h0042, "R6 peripheral high byte write");
        acc(0, 0, 22'h3FF904, 16'h0, "R6 peripheral word after byte");
        acc(0, 1, 22'h3FF905, 16'h0, "R6 peripheral byte read");

        acc(0, 0, 22'h3C0000, 16'h0, "R8 window base unclaimed");
        acc(1, 0, 22'h3FF000, 16'h9999, "R8 unclaimed write");
        acc(1, 1, 22'h3FF908, 16'h0001, "R8 just past claimed");

        acc(1, 0, 22'h3FFFFE, 16'h1234, "R7 psw word write");
        acc(0, 0, 22'h3FFFFE, 16'h0, "R7 psw word read");
        acc(1, 1, 22'h3FFFFF, 16'h00CD, "R7 psw high byte");
        acc(0, 0, 22'h3FFFFE, 16'h0, "R7 psw after byte");
        acc(0, 1, 22'h3FFFFE, 16'h0, "R7 psw low byte read");
        acc(1, 0, 22'h3FFFFF, 16'h7777, "R1 odd psw word");
        acc(0, 0, 22'h3FFFFE, 16'h0, "R7 psw unchanged by odd");

        for (int i = 0; i < 400; i++) begin
            int unsigned cat;
            logic [21:0] a;
            cat = $urandom_range(0, 9);
            if (cat <= 5) a = 22'($urandom_range(0, RB - 1));
            else if (cat == 6) a = 22'h3FF900 + 22'($urandom_range(0, 7));
            else if (cat == 7) a = 22'h3FFFFE + 22'($urandom_range(0, 1));
            else if (cat == 8) a = 22'($urandom_range(RB, 32'h3BFFFF));
            else a = 22'h3C0000 + 22'($urandom_range(0, 255));
            acc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a,
                16'($urandom), "R9 R10 random mix");
        end
        idle_check("R10 end");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule